// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock Controller

This block decides, each cycle, where the two ALU operands of the instruction in the execute stage of a five-stage in-order integer pipeline come from. An operand can come from the register-file read, from the result in the execute-to-memory register, or from the value in the memory-to-writeback register. When both later stages hold a result for the same register, the newer execute-to-memory result is used. A destination of register 0 is never forwarded.

The block also compares a load in execute with the two source fields of the instruction in decode. When a load's destination matches either source, it raises a one-cycle interlock. During the interlock the program counter and the fetch/decode register hold their values, and an all-zero control word is loaded into the decode/execute register. The load keeps moving down the pipe, so the dependent instruction later takes the loaded value from the writeback path.

The block comes with a small register harness that holds the PC, the fetch/decode register and the three later pipeline registers. With it, the stall and bubble timing can be seen cycle by cycle at the ports. The register file is written in the first half of a cycle and read in the second half, so a value being written back needs no bypass into decode.

Top module: `hazard_pipe`

## Requirements
- R1: While rst_ni is low, pc_o is 0, stall_o is 0, ex_live_o is 0 and both select outputs are 0. pc_we_o and ifid_we_o are 1 and idex_bubble_o is 0.
- R2: A select output is 1 when the execute/memory stage writes a nonzero register that equals that operand's source in execute. Operand A uses source 1 (bits 25..21) and operand B uses source 2 (bits 20..16).
- R3: A select output is 2 when the memory/writeback stage writes a nonzero register that equals that operand's source, and the execute/memory stage does not.
- R4: When both later stages write the operand's register, the select output is 1.
- R5: A destination of register 0 never causes forwarding; the select stays 0.
- R6: stall_o is 1 only when the instruction in execute is a load (opcode 0x23) and its destination equals source 1 or source 2 of a valid instruction in decode. A producer that is not a load never stalls.
- R7: While stall_o is 1, pc_we_o and ifid_we_o are 0 and idex_bubble_o is 1. The PC and the decode instruction then hold for one cycle.
- R8: Each load-use pair stalls for exactly one cycle. In the next cycle the execute stage holds a bubble (ex_live_o = 0), and the consumer then takes operand select 2.
- R9: The destination is bits 15..11 for opcode 0x00 (register format). It is bits 20..16 for opcode 0x23 (load) and opcode 0x0D (or-immediate). Opcode 0x2B (store) and all other opcodes write no register.
- R10: When there is no stall, pc_o advances by 4 each cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_instr_i | input | 32 | Instruction word at address pc_o |
| pc_o | output | 32 | Program counter |
| pc_we_o | output | 1 | PC write enable |
| ifid_we_o | output | 1 | Fetch/decode register write enable |
| idex_bubble_o | output | 1 | Bubble insert into decode/execute register |
| fwd_a_o | output | 2 | Operand A source: 0 register file, 1 execute/memory, 2 writeback |
| fwd_b_o | output | 2 | Operand B source, same encoding |
| stall_o | output | 1 | Load-use interlock |
| ex_live_o | output | 1 | Execute stage holds an instruction (not a bubble) |

## Verification
The assertions check on every cycle that an interlock freezes the PC and never lasts two cycles back to back. They also check that the cycle after an interlock holds a bubble, that the PC steps by 4 otherwise, that a nonzero select is never paired with a register-0 source, and that a stall only happens with a load in execute. Only the bench scenarios can show that the right select is chosen:
- after an adjacent dependence, a distance-two dependence, a double match and a register-0 write;
- that the immediate format's destination field is honoured;
- that a load followed by a non-dependent instruction, or by one two slots away, does not stall.

// File: rtl/hazard_pkg.sv
package hazard_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_AW  = 5;
  localparam int unsigned OP_W    = 6;

  localparam logic [OP_W-1:0] OP_RFMT  = 6'h00;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;

  typedef enum logic [1:0] {
    SEL_RF = 2'd0,
    SEL_EM = 2'd1,
    SEL_WB = 2'd2
  } opnd_sel_e;

  typedef struct packed {
    logic reg_we;
    logic mem_rd;
    logic mem_wr;
  } ctrl_t;

  typedef struct packed {
    ctrl_t             ctrl;
    logic [REG_AW-1:0] src1;
    logic [REG_AW-1:0] src2;
    logic [REG_AW-1:0] dst;
  } slot_t;

  typedef struct packed {
    logic              we;
    logic              ld;
    logic [REG_AW-1:0] dst;
  } wr_t;
endpackage

// File: rtl/hazard_decode.sv
module hazard_decode
  import hazard_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  input  logic               valid_i,
  output slot_t              slot_o
);
  logic [OP_W-1:0] op;
  logic            dst_rd;
  ctrl_t           ctrl;

  assign op = instr_i[31:26];

  always_comb begin
    ctrl   = '0;
    dst_rd = 1'b0;
    unique case (op)
      OP_RFMT:  begin ctrl.reg_we = 1'b1; dst_rd = 1'b1; end
      OP_LOAD:  begin ctrl.reg_we = 1'b1; ctrl.mem_rd = 1'b1; end
      OP_ORI:   ctrl.reg_we = 1'b1;
      OP_STORE: ctrl.mem_wr = 1'b1;
      default:  ctrl = '0;
    endcase
    if (!valid_i) ctrl = '0;
  end

  assign slot_o.ctrl = ctrl;
  assign slot_o.src1 = instr_i[25:21];
  assign slot_o.src2 = instr_i[20:16];
  assign slot_o.dst  = dst_rd ? instr_i[15:11] : instr_i[20:16];
endmodule

// File: rtl/hazard_fwd.sv
module hazard_fwd
  import hazard_pkg::*;
#(
  parameter int unsigned N_OPND = 2
) (
  input  logic [N_OPND-1:0][REG_AW-1:0] src_i,
  input  wr_t                           em_i,
  input  wr_t                           mw_i,
  output logic [N_OPND-1:0][1:0]        sel_o
);
  logic em_live, mw_live;

  // register 0 is hard-wired, never a bypass source
  assign em_live = em_i.we && (em_i.dst != '0);
  assign mw_live = mw_i.we && (mw_i.dst != '0);

  for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
    logic hit_em, hit_mw;
    assign hit_em = em_live && (em_i.dst == src_i[k]);
    assign hit_mw = mw_live && (mw_i.dst == src_i[k]);
    always_comb begin
      if (hit_em)      sel_o[k] = SEL_EM;
      else if (hit_mw) sel_o[k] = SEL_WB;
      else             sel_o[k] = SEL_RF;
    end
  end
endmodule

// File: rtl/hazard_stall.sv
module hazard_stall
  import hazard_pkg::*;
(
  input  slot_t id_i,
  input  logic  id_valid_i,
  input  slot_t ex_i,
  output logic  stall_o
);
  logic ex_is_load;
  logic src_hit;

  assign ex_is_load = ex_i.ctrl.mem_rd && ex_i.ctrl.reg_we;
  assign src_hit    = (ex_i.dst == id_i.src1) || (ex_i.dst == id_i.src2);
  assign stall_o    = id_valid_i && ex_is_load && src_hit;
endmodule

// File: rtl/hazard_pipe.sv
module hazard_pipe
  import hazard_pkg::*;
#(
  parameter int unsigned PC_W    = 32,
  parameter int unsigned PC_STEP = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [31:0]        fetch_instr_i,
  output logic [PC_W-1:0]    pc_o,
  output logic               pc_we_o,
  output logic               ifid_we_o,
  output logic               idex_bubble_o,
  output logic [1:0]         fwd_a_o,
  output logic [1:0]         fwd_b_o,
  output logic               stall_o,
  output logic               ex_live_o
);
  localparam int unsigned N_OPND = 2;
  localparam logic [PC_W-1:0] PC_INC = PC_W'(PC_STEP);

  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] ifid_instr_q;
  logic               ifid_valid_q;
  slot_t              id_slot;
  slot_t              idex_q;
  wr_t                exmem_q;
  wr_t                memwb_q;
  logic               stall;
  logic [N_OPND-1:0][REG_AW-1:0] ex_src;
  logic [N_OPND-1:0][1:0]        ex_sel;

  hazard_decode u_decode (
    .instr_i (ifid_instr_q),
    .valid_i (ifid_valid_q),
    .slot_o  (id_slot)
  );

  hazard_stall u_stall (
    .id_i       (id_slot),
    .id_valid_i (ifid_valid_q),
    .ex_i       (idex_q),
    .stall_o    (stall)
  );

  assign ex_src[0] = idex_q.src1;
  assign ex_src[1] = idex_q.src2;

  hazard_fwd #(.N_OPND(N_OPND)) u_fwd (
    .src_i (ex_src),
    .em_i  (exmem_q),
    .mw_i  (memwb_q),
    .sel_o (ex_sel)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (!stall) pc_q <= pc_q + PC_INC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ifid_instr_q <= '0;
      ifid_valid_q <= 1'b0;
    end else if (!stall) begin
      ifid_instr_q <= fetch_instr_i;
      ifid_valid_q <= 1'b1;
    end
  end

  // bubble clears the whole slot so a stale source cannot forward
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idex_q <= '0;
    else if (stall) idex_q <= '0;
    else            idex_q <= id_slot;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exmem_q <= '0;
      memwb_q <= '0;
    end else begin
      exmem_q.we  <= idex_q.ctrl.reg_we;
      exmem_q.ld  <= idex_q.ctrl.mem_rd;
      exmem_q.dst <= idex_q.dst;
      memwb_q     <= exmem_q;
    end
  end

  assign pc_o          = pc_q;
  assign pc_we_o       = !stall;
  assign ifid_we_o     = !stall;
  assign idex_bubble_o = stall;
  assign stall_o       = stall;
  assign fwd_a_o       = ex_sel[0];
  assign fwd_b_o       = ex_sel[1];
  assign ex_live_o     = |idex_q.ctrl;
endmodule

// File: rtl/hazard_pipe_chk.sv
module hazard_pipe_chk #(
  parameter int unsigned PC_W = 32
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_o,
  input logic            stall_o,
  input logic            ex_live_o,
  input logic [1:0]      fwd_a_o,
  input logic [1:0]      fwd_b_o,
  input logic [4:0]      ex_src1_i,
  input logic [4:0]      ex_src2_i,
  input logic            ex_load_i
);
  assert_pc_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> $stable(pc_o));

  assert_pc_step_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_o |=> (pc_o == $past(pc_o) + PC_W'(4)));

  assert_single_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  assert_bubble_after_stall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !ex_live_o);

  assert_r0_a_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o != 2'd0) |-> (ex_src1_i != 5'd0));

  assert_r0_b_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_b_o != 2'd0) |-> (ex_src2_i != 5'd0));

  assert_stall_needs_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ex_load_i);
endmodule

bind hazard_pipe hazard_pipe_chk #(.PC_W(PC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .pc_o      (pc_o),
  .stall_o   (stall_o),
  .ex_live_o (ex_live_o),
  .fwd_a_o   (fwd_a_o),
  .fwd_b_o   (fwd_b_o),
  .ex_src1_i (idex_q.src1),
  .ex_src2_i (idex_q.src2),
  .ex_load_i (idex_q.ctrl.mem_rd)
);

// File: tb/hazard_pipe_tb_top.sv
module hazard_pipe_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_instr_i;
  logic [31:0] pc_o;
  logic        pc_we_o, ifid_we_o, idex_bubble_o, stall_o, ex_live_o;
  logic [1:0]  fwd_a_o, fwd_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int stall_seen = 0;

  logic [31:0] prog [64];
  int m_pc, m_id, m_ex, m_mem, m_wb;

  always #5ns clk_i = ~clk_i;

  assign fetch_instr_i = prog[pc_o[7:2]];

  hazard_pipe dut_i (
    .clk_i, .rst_ni, .fetch_instr_i, .pc_o, .pc_we_o, .ifid_we_o,
    .idex_bubble_o, .fwd_a_o, .fwd_b_o, .stall_o, .ex_live_o
  );

  function automatic logic [31:0] e_add(int rd, int rs, int rt);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'h20};
  endfunction
  function automatic logic [31:0] e_imm(logic [5:0] op, int rt, int rs, int imm);
    return {op, 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // reference view of the instruction set (R9)
  function automatic bit m_writes(logic [31:0] w);
    return (w[31:26] == 6'h00) || (w[31:26] == 6'h23) || (w[31:26] == 6'h0D);
  endfunction
  function automatic int m_dst(logic [31:0] w);
    if (w[31:26] == 6'h00) return int'(w[15:11]);
    return int'(w[20:16]);
  endfunction
  function automatic int m_src(logic [31:0] w, int k);
    return (k == 0) ? int'(w[25:21]) : int'(w[20:16]);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_stall();
    if (m_ex < 0 || m_id < 0) return 0;
    if (prog[m_ex][31:26] != 6'h23) return 0;
    return int'(m_dst(prog[m_ex]) == m_src(prog[m_id], 0) ||
                m_dst(prog[m_ex]) == m_src(prog[m_id], 1));
  endfunction

  task automatic check_sel(int k, int act);
    int src;
    bit h1, h2;
    string tag;
    int exp;
    if (m_ex < 0) begin
      chk("R8 bubble select", act, 0);
      return;
    end
    src = m_src(prog[m_ex], k);
    h1 = (m_mem >= 0) && m_writes(prog[m_mem]) && m_dst(prog[m_mem]) != 0 &&
         m_dst(prog[m_mem]) == src;
    h2 = (m_wb >= 0) && m_writes(prog[m_wb]) && m_dst(prog[m_wb]) != 0 &&
         m_dst(prog[m_wb]) == src;
    exp = h1 ? 1 : (h2 ? 2 : 0);
    if (h1 && h2)   tag = "R4 both match";
    else if (h1)    tag = "R2 ex/mem select";
    else if (h2)    tag = "R3 wb select";
    else if (src == 0) tag = "R5 r0 select";
    else            tag = "R2 no match";
    chk(tag, act, exp);
  endtask

  task automatic advance();
    int st;
    st = m_stall();
    m_wb  = m_mem;
    m_mem = m_ex;
    m_ex  = st ? -1 : m_id;
    if (!st) begin
      m_id = m_pc;
      m_pc = m_pc + 1;
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) prog[i] = 32'h0;
    prog[0]  = e_add(1, 2, 3);
    prog[1]  = e_add(4, 1, 5);
    prog[2]  = e_add(6, 7, 1);
    prog[3]  = e_add(8, 6, 6);
    prog[4]  = e_add(6, 9, 9);
    prog[5]  = e_imm(6'h0D, 6, 10, 1);
    prog[6]  = e_add(11, 6, 6);
    prog[7]  = e_add(0, 1, 1);
    prog[8]  = e_add(12, 0, 0);
    prog[9]  = e_imm(6'h23, 13, 2, 0);
    prog[10] = e_add(14, 13, 1);
    prog[11] = e_imm(6'h2B, 13, 14, 4);
    prog[12] = e_imm(6'h23, 15, 3, 0);
    prog[13] = e_add(16, 3, 15);
    prog[14] = e_imm(6'h23, 17, 1, 0);
    prog[15] = e_add(18, 1, 2);
    prog[16] = e_add(19, 17, 17);
    prog[17] = e_add(20, 5, 5);
    prog[18] = e_add(21, 20, 1);
    prog[19] = e_imm(6'h23, 22, 4, 0);
    prog[20] = e_imm(6'h0D, 23, 22, 7);
    m_pc = 0; m_id = -1; m_ex = -1; m_mem = -1; m_wb = -1;

    repeat (3) @(negedge clk_i);
    chk("R1 pc", int'(pc_o), 0);
    chk("R1 stall", int'(stall_o), 0);
    chk("R1 live", int'(ex_live_o), 0);
    chk("R1 fwd_a", int'(fwd_a_o), 0);
    chk("R1 fwd_b", int'(fwd_b_o), 0);
    chk("R1 pc_we", int'(pc_we_o), 1);
    chk("R1 bubble", int'(idex_bubble_o), 0);
    rst_ni = 1'b1;
    advance();

    for (int cyc = 0; cyc < 40; cyc++) begin
      int st;
      @(negedge clk_i);
      st = m_stall();
      chk("R10 pc", int'(pc_o), 4 * m_pc);
      chk("R6 stall", int'(stall_o), st);
      chk("R7 pc_we", int'(pc_we_o), 1 - st);
      chk("R7 ifid_we", int'(ifid_we_o), 1 - st);
      chk("R7 bubble", int'(idex_bubble_o), st);
      chk("R8 ex live", int'(ex_live_o), int'(m_ex >= 0));
      check_sel(0, int'(fwd_a_o));
      check_sel(1, int'(fwd_b_o));
      if (m_ex == 6) begin
        chk("R9 ori dst via rt, A", int'(fwd_a_o), 1);
        chk("R9 ori dst via rt, B", int'(fwd_b_o), 1);
      end
      if (m_ex == 8) chk("R5 r0 write not forwarded", int'(fwd_a_o), 0);
      if (m_ex == 10) chk("R8 consumer takes wb value", int'(fwd_a_o), 2);
      if (m_ex == 16) chk("R6 load at distance two no stall, R3", int'(fwd_a_o), 2);
      if (stall_o) stall_seen++;
      advance();
    end
    chk("R8 stall count", stall_seen, 3);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100us;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule